// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that lets a host reach a small register and RAM map. All of its logic runs on the system clock. The serial clock, chip enable and data input are resynchronised and their edges detected, so that no logic is clocked by the serial clock itself. A static mode input selects one of two protocols. The first is four-wire SPI, with separate data in and data out. The second is a 3-wire protocol, in which data in and data out share one line that this block drives only while it returns read data.

Each transfer starts once chip enable goes high, with an address byte. Its top bit selects the direction and its lower seven bits give the location. Data bytes follow, and the address advances after each one, so one transfer can move a burst of bytes. The address wraps within its region: the clock registers occupy 00h to 1Fh and the user RAM occupies 20h to 7Fh.

The block does three further things on the way to the register file. When a read begins, it freezes a copy of the live time bytes, so a burst sees one consistent time. It holds the write-protect bit and uses it to gate every write strobe. It returns zero for the reserved clock locations and never writes them. The register file and the timekeeping logic sit outside the block and connect through a simple address, write and read-data port.

Top module: `serial_reg_port`

## Requirements
- R1: With `spi_mode`=1, bits move MSB first. Input is sampled on the rising serial clock edge and output changes on the falling edge. `sdo_oe` is high whenever chip enable is high.
- R2: With `spi_mode`=0 (3-wire), `sdo_oe` is high only during the data bytes of a read transfer, and is low during the address byte, during write data and while chip enable is low.
- R3: The first byte after chip enable rises is the address. Bit 7 = 1 selects a write, bit 7 = 0 selects a read, and bits 6:0 give the location.
- R4: After each data byte the address advances by one. Within 00h–1Fh it wraps from 1Fh to 00h, and within 20h–7Fh it wraps from 7Fh to 20h.
- R5: When a read address byte completes, locations 00h to NTIME-1 are captured from `live_time` (byte k = bits 8k+7:8k). Reads of those locations return this copy for the rest of the transfer.
- R6: Locations 12h–1Fh read as 00h. Writes to them (addresses 92h–9Fh) produce no write strobe.
- R7: A data byte is written only once all 8 of its bits have arrived. If chip enable drops earlier, no strobe is issued for that byte.
- R8: Write protect is bit 6 of the control register at 0Fh. When it is 1, no write strobe is issued, but a write to 0Fh still updates the bit. Reads of 0Fh return the bit in position 6, and `wp` shows it.
- R9: After reset, `sdo_oe`, `reg_we` and `wp` are 0.
- R10: Chip enable going low ends the transfer. The next transfer starts again with an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_mode | input | 1 | Static protocol select: 1 = SPI, 0 = 3-wire |
| ce | input | 1 | Chip enable, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in (the shared line in 3-wire mode) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| reg_addr | output | 7 | Register file address |
| reg_we | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr` (combinational) |
| live_time | input | 8*NTIME | Live time bytes, byte k at bits 8k+7:8k |
| wp | output | 1 | Current write-protect bit |

## Verification
A 96-byte burst write followed by a 97-byte burst read sweeps the whole RAM. The data is arithmetic, so a misplaced address, a wrong bit order or a missed wrap shows up as a wrong byte. Short bursts that start at 1Eh, 1Fh and 7Eh show whether each region wraps on its own boundary and whether the reserved locations hide their contents. A change to `live_time` in the middle of a burst separates a frozen copy from a live pass-through. Writes made with protect set and cleared, together with a byte cut off after five bits, separate blocked, partial and completed writes. The 3-wire runs watch the shared line for two drivers at once.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam logic [6:0] CLK_TOP  = 7'h1F;
  localparam logic [6:0] RAM_BASE = 7'h20;
  localparam logic [6:0] RAM_TOP  = 7'h7F;
  localparam logic [6:0] RSV_LO   = 7'h12;
  localparam logic [6:0] CTRL_LOC = 7'h0F;
  localparam int         WP_POS   = 6;

  typedef enum logic { PH_ADDR, PH_DATA } phase_t;

  function automatic logic [6:0] next_loc(input logic [6:0] a);
    if (a <= CLK_TOP)      return {2'b00, a[4:0] + 5'd1};
    else if (a == RAM_TOP) return RAM_BASE;
    else                   return a + 7'd1;
  endfunction

  function automatic logic is_rsv(input logic [6:0] a);
    return (a >= RSV_LO) && (a <= CLK_TOP);
  endfunction
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_one
      logic r;
      always_ff @(posedge clk) begin
        if (rst) r <= 1'b0;
        else     r <= d;
      end
      assign q = r;
    end else begin : g_chain
      logic [STAGES-1:0] r;
      always_ff @(posedge clk) begin
        if (rst) r <= '0;
        else     r <= {r[STAGES-2:0], d};
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/srp_snapshot.sv
module srp_snapshot #(
  parameter int NTIME = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [8*NTIME-1:0] live,
  input  logic [6:0]       idx,
  output logic             hit,
  output logic [7:0]       q
);
  logic [7:0] buf_q [NTIME];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTIME; k++) buf_q[k] <= '0;
    end else if (cap) begin
      for (int k = 0; k < NTIME; k++) buf_q[k] <= live[8*k +: 8];
    end
  end

  always_comb begin
    hit = 1'b0;
    q   = '0;
    for (int k = 0; k < NTIME; k++) begin
      if (idx == 7'(k)) begin
        hit = 1'b1;
        q   = buf_q[k];
      end
    end
  end

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(buf_q[0]));
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int SYNC_STAGES = 2,
  parameter int NTIME       = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               spi_mode,
  input  logic               ce,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo,
  output logic               sdo_oe,
  output logic [6:0]         reg_addr,
  output logic               reg_we,
  output logic [7:0]         reg_wdata,
  input  logic [7:0]         reg_rdata,
  input  logic [8*NTIME-1:0] live_time,
  output logic               wp
);
  import srp_pkg::*;

  localparam int NSIG = 3;

  logic [NSIG-1:0] raw, syn;
  assign raw = {ce, sclk, sdi};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    srp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(raw[g]), .q(syn[g])
    );
  end

  logic ce_s, sclk_s, sdi_s, sclk_d;
  assign ce_s   = syn[2];
  assign sclk_s = syn[1];
  assign sdi_s  = syn[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  logic rise, fall;
  assign rise = ce_s &  sclk_s & ~sclk_d;
  assign fall = ce_s & ~sclk_s &  sclk_d;

  phase_t     phase;
  logic [2:0] bitcnt;
  logic [6:0] shin;
  logic [7:0] shout;
  logic [6:0] addr_q, wr_addr_q;
  logic       is_wr, wp_q, we_q, sdo_q, oe_q;
  logic [7:0] wdata_q;

  logic [7:0] byte_in;
  logic       byte_end, cap, adv;
  assign byte_in  = {shin, sdi_s};
  assign byte_end = rise && (bitcnt == 3'd7);
  assign cap      = byte_end && (phase == PH_ADDR) && !byte_in[7];
  assign adv      = byte_end && (phase == PH_DATA);

  logic       snap_hit;
  logic [7:0] snap_byte;

  srp_snapshot #(.NTIME(NTIME)) u_snap (
    .clk(clk), .rst(rst), .cap(cap), .live(live_time),
    .idx(addr_q), .hit(snap_hit), .q(snap_byte)
  );

  logic [7:0] rd_byte;
  always_comb begin
    rd_byte = reg_rdata;
    if (snap_hit)                rd_byte = snap_byte;
    else if (is_rsv(addr_q))     rd_byte = '0;
    else if (addr_q == CTRL_LOC) rd_byte[WP_POS] = wp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_ADDR;
      bitcnt    <= '0;
      shin      <= '0;
      shout     <= '0;
      addr_q    <= '0;
      wr_addr_q <= '0;
      is_wr     <= 1'b0;
      wp_q      <= 1'b0;
      we_q      <= 1'b0;
      wdata_q   <= '0;
      sdo_q     <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      oe_q <= ce_s && (spi_mode || (phase == PH_DATA && !is_wr));
      if (!ce_s) begin
        phase  <= PH_ADDR;
        bitcnt <= '0;
      end else if (rise) begin
        shin   <= byte_in[6:0];
        bitcnt <= bitcnt + 3'd1;
        if (byte_end) begin
          if (phase == PH_ADDR) begin
            addr_q <= byte_in[6:0];
            is_wr  <= byte_in[7];
            phase  <= PH_DATA;
          end else begin
            if (is_wr) begin
              if (!wp_q && !is_rsv(addr_q)) begin
                we_q      <= 1'b1;
                wdata_q   <= byte_in;
                wr_addr_q <= addr_q;
              end
              if (addr_q == CTRL_LOC) wp_q <= byte_in[WP_POS];
            end
            addr_q <= next_loc(addr_q);
          end
        end
      end else if (fall && phase == PH_DATA && !is_wr) begin
        if (bitcnt == 3'd0) begin
          sdo_q <= rd_byte[7];
          shout <= {rd_byte[6:0], 1'b0};
        end else begin
          sdo_q <= shout[7];
          shout <= {shout[6:0], 1'b0};
        end
      end
    end
  end

  assign sdo       = sdo_q;
  assign sdo_oe    = oe_q;
  assign reg_we    = we_q;
  assign reg_wdata = wdata_q;
  assign reg_addr  = we_q ? wr_addr_q : addr_q;
  assign wp        = wp_q;

  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !$past(wp_q));
  // R6
  rsv_write_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !((reg_addr >= 7'h12) && (reg_addr <= 7'h1F)));
  // R4
  clk_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && addr_q <= 7'h1F) |=> (addr_q <= 7'h1F));
  // R4
  ram_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && addr_q >= 7'h20) |=> (addr_q >= 7'h20));
  // R2
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> !sdo_oe);
  // R1
  spi_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_s && spi_mode) |=> sdo_oe);
  // R7
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
endmodule

// File: tb/serial_reg_port_bench.sv
`timescale 1ns/1ps
module serial_reg_port_bench;
  localparam int NTIME = 7;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, spi_mode, ce, sclk, host_drv, host_bit;
  logic sdo, sdo_oe, reg_we, wp;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [8*NTIME-1:0] live_time;
  logic line;

  assign line = (!spi_mode && sdo_oe) ? sdo : (host_drv ? host_bit : 1'b0);

  serial_reg_port #(.SYNC_STAGES(2), .NTIME(NTIME)) u_serial_reg_port (
    .clk(clk), .rst(rst), .spi_mode(spi_mode), .ce(ce), .sclk(sclk),
    .sdi(line), .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .live_time(live_time), .wp(wp)
  );

  logic [7:0] mem [128];
  logic       pre_en;
  logic [6:0] pre_a;
  logic [7:0] pre_d;
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (pre_en)      mem[pre_a] <= pre_d;
    else if (reg_we) mem[reg_addr] <= reg_wdata;
  end

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] wbuf [128];
  logic [7:0] rbuf [128];

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !spi_mode && host_drv && sdo_oe) begin
      fails++;
      $display("FAIL R2: actual two drivers expected one");
    end
  end

  task automatic preset(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); pre_en = 1; pre_a = a; pre_d = d;
    @(negedge clk); pre_en = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, input logic drv, input logic rel, output logic got);
    host_bit = b; host_drv = drv;
    wait_n(HALF);
    got = spi_mode ? sdo : line;
    sclk = 1;
    wait_n(1);
    if (rel) host_drv = 0;
    wait_n(HALF - 1);
    sclk = 0;
  endtask

  task automatic xbyte(input logic [7:0] b, input logic drv, input logic rel,
                       input int nbits, output logic [7:0] got);
    logic g;
    got = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      xbit(b[i], drv, rel && (i == 0), g);
      got[i] = g;
    end
  endtask

  task automatic start();
    ce = 1;
    wait_n(HALF);
    chk({7'd0, sdo_oe}, {7'd0, spi_mode}, spi_mode ? "R1 oe" : "R2 oe");
  endtask

  task automatic stop();
    wait_n(HALF);
    ce = 0; host_drv = 0;
    wait_n(2 * HALF);
    chk({7'd0, sdo_oe}, 8'd0, "R2 released");
  endtask

  task automatic do_write(input logic [6:0] a, input int n, input int lastbits);
    logic [7:0] g;
    start();
    xbyte({1'b1, a}, 1, 0, 8, g);
    for (int i = 0; i < n; i++) xbyte(wbuf[i], 1, 0, (i == n - 1) ? lastbits : 8, g);
    stop();
  endtask

  task automatic do_read(input logic [6:0] a, input int n, input bit chg);
    logic [7:0] g;
    start();
    xbyte({1'b0, a}, 1, !spi_mode, 8, g);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, spi_mode, 0, 8, rbuf[i]);
      if (i == 0) chk({7'd0, sdo_oe}, 8'd1, "R2 read drive");
      if (chg && i == 0) live_time = {NTIME{8'hEE}};
    end
    stop();
  endtask

  initial begin
    int lim;
    lim = 200000;
    repeat (lim) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; spi_mode = 1; ce = 0; sclk = 0; host_drv = 0; host_bit = 0;
    pre_en = 0; pre_a = '0; pre_d = '0;
    for (int k = 0; k < NTIME; k++) live_time[8*k +: 8] = 8'h10 + 8'(k);
    wait_n(5);
    rst = 0;
    wait_n(1);
    // R9 reset state
    chk({7'd0, sdo_oe}, 8'd0, "R9 sdo_oe");
    chk({7'd0, reg_we}, 8'd0, "R9 reg_we");
    chk({7'd0, wp}, 8'd0, "R9 wp");
    preset(7'h15, 8'hAA);
    preset(7'h1F, 8'h5A);
    preset(7'h0F, 8'h00);
    preset(7'h08, 8'h3C);

    // R3 R1: full RAM burst write then burst read with wrap (R4)
    for (int i = 0; i < 96; i++) wbuf[i] = 8'((i * 37 + 5) & 255);
    do_write(7'h20, 96, 8);
    for (int i = 0; i < 96; i++) chk(mem[32 + i], 8'((i * 37 + 5) & 255), "R3 write");
    do_read(7'h20, 97, 0);
    for (int i = 0; i < 97; i++) chk(rbuf[i], 8'(((i % 96) * 37 + 5) & 255), "R1 R4 read");
    do_read(7'h08, 1, 0);
    chk(rbuf[0], 8'h3C, "R3 read");

    // R5 snapshot frozen during burst
    do_read(7'h00, NTIME, 1);
    for (int k = 0; k < NTIME; k++) chk(rbuf[k], 8'h10 + 8'(k), "R5 frozen");
    do_read(7'h00, 1, 0);
    chk(rbuf[0], 8'hEE, "R5 recapture");

    // R6 reserved
    do_read(7'h15, 1, 0);
    chk(rbuf[0], 8'h00, "R6 read");
    wbuf[0] = 8'h55;
    do_write(7'h15, 1, 8);
    chk(mem[7'h15], 8'hAA, "R6 write");
    do_read(7'h1E, 3, 0);
    chk(rbuf[0], 8'h00, "R6 1E");
    chk(rbuf[1], 8'h00, "R6 1F");
    chk(rbuf[2], 8'hEE, "R4 clock wrap read");
    wbuf[0] = 8'h77; wbuf[1] = 8'h99;
    do_write(7'h1F, 2, 8);
    chk(mem[7'h1F], 8'h5A, "R6 1F kept");
    chk(mem[7'h00], 8'h99, "R4 clock wrap write");

    // R8 write protect
    wbuf[0] = 8'h40;
    do_write(7'h0F, 1, 8);
    chk({7'd0, wp}, 8'd1, "R8 set");
    chk(mem[7'h0F], 8'h40, "R8 ctrl write");
    wbuf[0] = 8'h12;
    do_write(7'h21, 1, 8);
    chk(mem[7'h21], 8'((1 * 37 + 5) & 255), "R8 blocked");
    wbuf[0] = 8'h47;
    do_write(7'h0F, 1, 8);
    chk({7'd0, wp}, 8'd1, "R8 held");
    chk(mem[7'h0F], 8'h40, "R8 ctrl blocked");
    do_read(7'h0F, 1, 0);
    chk(rbuf[0], 8'h40, "R8 read bit6");
    wbuf[0] = 8'h03;
    do_write(7'h0F, 1, 8);
    chk({7'd0, wp}, 8'd0, "R8 clear");
    chk(mem[7'h0F], 8'h40, "R8 ctrl still blocked");
    do_read(7'h0F, 1, 0);
    chk(rbuf[0], 8'h00, "R8 read cleared");
    wbuf[0] = 8'h12;
    do_write(7'h21, 1, 8);
    chk(mem[7'h21], 8'h12, "R8 unblocked");

    // R7 R10 cut-short byte
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    do_write(7'h25, 2, 5);
    chk(mem[7'h25], 8'h11, "R7 full byte");
    chk(mem[7'h26], 8'((6 * 37 + 5) & 255), "R7 partial dropped");
    do_read(7'h25, 1, 0);
    chk(rbuf[0], 8'h11, "R10 restart");

    // R2 3-wire, including RAM wrap at 7Fh
    spi_mode = 0;
    wait_n(4);
    for (int i = 0; i < 16; i++) wbuf[i] = 8'((i * 91 + 200) & 255);
    do_write(7'h7E, 16, 8);
    do_read(7'h7E, 16, 0);
    for (int i = 0; i < 16; i++) chk(rbuf[i], 8'((i * 91 + 200) & 255), "R2 R4 3-wire");
    chk(mem[7'h20], 8'((2 * 91 + 200) & 255), "R4 ram wrap");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule